// File: doc/BRIEF.md
# Predicated Multi-Lane Vector Execution Unit

This block executes vector instructions across a row of identical lanes. A single decoded instruction (operation, register selects, an immediate and a base address) is presented on the issue port, and every lane applies it at the same moment to its own small register file. Each lane holds one element of each vector register, so a vector of `LANES` elements lives as one word per lane in the same register index.

Data moves between the lanes and memory as whole blocks. A vector load asks for one contiguous block at the base address and hands word i of the returned block to lane i. A vector store gathers the selected register from every lane into one block and writes it in a single access. The memory port uses a valid/ready request and a separate response strobe. Issue is held off until the response arrives.

Conditional work under the shared control stream uses a one-bit flag in each lane. A vector compare sets or clears the flag per lane, and an instruction issued with its predicate bit set updates only the lanes whose flag is true. The flags come out of reset true, so predicated and plain forms act the same until the first compare.

Top module: `vsimd_unit`

## Requirements
- R1: After reset `in_ready` is 1, `mem_req_valid` is 0, every lane register reads as zero and every lane flag is true (so a predicated instruction before any compare updates all lanes).
- R2: Op code 1 (vector add) writes `va + vb` modulo 2^32 into register `vd` of each lane, the result visible to the next instruction.
- R3: Op code 2 (add immediate) writes `va + in_imm` modulo 2^32 into register `vd` of each lane.
- R4: Op code 3 (compare) sets each lane's flag to 1 when its `va` word is less than its `vb` word as signed 32-bit integers, else 0 (equal gives 0); it changes no register and ignores `in_pred`.
- R5: An add or add-immediate issued with `in_pred`=1 writes register `vd` only in lanes whose flag is 1; other lanes keep their old value.
- R6: Op code 4 (load) issues a read request with `mem_req_write`=0 and `mem_req_addr`=`in_base`; the response word at bits [32*i+31:32*i] is written into register `vd` of lane i.
- R7: Op code 5 (store) issues a request with `mem_req_write`=1, `mem_req_addr`=`in_base`, and `mem_req_wdata` bits [32*i+31:32*i] equal to lane i's register `va`; predication has no effect on a store.
- R8: Once a load or store is accepted, `in_ready` stays 0 and `mem_req_valid` stays 1 with address and data unchanged until `mem_req_ready`; `in_ready` then stays 0 until the cycle after `mem_rsp_valid`.
- R9: An add or add-immediate with `in_pred`=0 writes all lanes regardless of their flags.
- R10: A load issued with `in_pred`=1 writes only the lanes whose flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted when high with `in_valid` |
| in_op | input | 3 | 0 none, 1 add, 2 add immediate, 3 compare, 4 load, 5 store |
| in_pred | input | 1 | Run only in lanes with flag set |
| in_vd | input | 3 | Destination register |
| in_va | input | 3 | First source register (store source) |
| in_vb | input | 3 | Second source register |
| in_imm | input | 32 | Immediate broadcast to all lanes |
| in_base | input | 32 | Block address for load and store |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_addr | output | 32 | Block address |
| mem_req_wdata | output | 512 | Store block, lane i at word i |
| mem_rsp_valid | input | 1 | Access complete (load data valid) |
| mem_rsp_rdata | input | 512 | Load block, word i to lane i |

## Verification
The hardest state to reach is a mixed flag pattern that differs from lane to lane, since the flags can only be set through a compare on data that first had to be loaded. The stimulus loads two vectors whose lanes are chosen so that a signed compare splits the lanes, with negative, positive and equal pairs. It then runs predicated adds and a predicated load against that pattern and reads every lane back through a store. The memory responder also varies its request and response delays to keep issue stalled across several cycles.

// File: rtl/vsimd_pkg.sv
package vsimd_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADDC  = 3'd2,
    OP_CMPLT = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5
  } vop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } vstate_e;

endpackage

// File: rtl/vsimd_ctrl.sv
module vsimd_ctrl
  import vsimd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RIW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  vop_e           in_op,
  input  logic           in_pred,
  input  logic [RIW-1:0] in_vd,
  input  logic [RIW-1:0] in_va,
  input  logic [AW-1:0]  in_base,
  input  logic           mem_req_ready,
  input  logic           mem_rsp_valid,
  output logic           in_ready,
  output logic           alu_fire,
  output logic           ld_fire,
  output logic           waiting,
  output logic           mem_req_valid,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [RIW-1:0] lat_vd,
  output logic [RIW-1:0] lat_va,
  output logic           lat_pred
);

  vstate_e state_q;
  logic    accept;
  logic    is_mem;

  assign in_ready      = (state_q == ST_IDLE);
  assign accept        = in_valid && in_ready;
  assign is_mem        = (in_op == OP_LOAD) || (in_op == OP_STORE);
  assign alu_fire      = accept && (in_op == OP_ADD || in_op == OP_ADDC || in_op == OP_CMPLT);
  assign mem_req_valid = (state_q == ST_REQ);
  assign waiting       = (state_q == ST_WAIT);
  assign ld_fire       = waiting && mem_rsp_valid && !mem_req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      lat_vd        <= '0;
      lat_va        <= '0;
      lat_pred      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept && is_mem) begin
          state_q       <= ST_REQ;
          mem_req_write <= (in_op == OP_STORE);
          mem_req_addr  <= in_base;
          lat_vd        <= in_vd;
          lat_va        <= in_va;
          lat_pred      <= in_pred;
        end
        ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vsimd_lane.sv
module vsimd_lane
  import vsimd_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alu_fire,
  input  vop_e           op,
  input  logic           pred_en,
  input  logic [RIW-1:0] vd,
  input  logic [RIW-1:0] va,
  input  logic [RIW-1:0] vb,
  input  logic [DW-1:0]  imm,
  input  logic           ld_fire,
  input  logic           ld_pred,
  input  logic [RIW-1:0] ld_vd,
  input  logic [DW-1:0]  ld_word,
  input  logic [RIW-1:0] st_va,
  output logic [DW-1:0]  st_word,
  output logic           flag_q,
  output logic           wr_ev
);

  function automatic logic [DW-1:0] lane_sum(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic lane_less(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] opa, opb, result;
  logic          alu_wr, ld_wr, cmp_wr;

  assign opa     = rf[va];
  assign opb     = (op == OP_ADDC) ? imm : rf[vb];
  assign result  = lane_sum(opa, opb);
  assign alu_wr  = alu_fire && (op == OP_ADD || op == OP_ADDC) && (!pred_en || flag_q);
  assign ld_wr   = ld_fire && (!ld_pred || flag_q);
  assign cmp_wr  = alu_fire && (op == OP_CMPLT);
  assign wr_ev   = alu_wr || ld_wr;
  assign st_word = rf[st_va];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
      flag_q <= 1'b1;
    end else begin
      if (alu_wr)     rf[vd]    <= result;
      else if (ld_wr) rf[ld_vd] <= ld_word;
      if (cmp_wr) flag_q <= lane_less(opa, rf[vb]);
    end
  end

endmodule

// File: rtl/vsimd_unit.sv
module vsimd_unit
  import vsimd_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int AW    = 32,
  localparam int RIW  = $clog2(NREG),
  localparam int BW   = LANES * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     in_op,
  input  logic           in_pred,
  input  logic [RIW-1:0] in_vd,
  input  logic [RIW-1:0] in_va,
  input  logic [RIW-1:0] in_vb,
  input  logic [DW-1:0]  in_imm,
  input  logic [AW-1:0]  in_base,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [BW-1:0]  mem_req_wdata,
  input  logic           mem_rsp_valid,
  input  logic [BW-1:0]  mem_rsp_rdata
);

  vop_e             op;
  logic             alu_fire, ld_fire, waiting, lat_pred;
  logic [RIW-1:0]   lat_vd, lat_va;
  logic [LANES-1:0] flag_vec, wr_mask;
  logic             cmp_fire, pred_alu_fire;

  assign op            = vop_e'(in_op);
  assign cmp_fire      = alu_fire && (op == OP_CMPLT);
  assign pred_alu_fire = alu_fire && in_pred;

  vsimd_ctrl #(.AW(AW), .RIW(RIW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(op), .in_pred(in_pred),
    .in_vd(in_vd), .in_va(in_va), .in_base(in_base),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .in_ready(in_ready), .alu_fire(alu_fire), .ld_fire(ld_fire), .waiting(waiting),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .lat_vd(lat_vd), .lat_va(lat_va), .lat_pred(lat_pred)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vsimd_lane #(.DW(DW), .NREG(NREG)) lane_i (
      .clk(clk), .rst_n(rst_n), .alu_fire(alu_fire), .op(op), .pred_en(in_pred),
      .vd(in_vd), .va(in_va), .vb(in_vb), .imm(in_imm),
      .ld_fire(ld_fire), .ld_pred(lat_pred), .ld_vd(lat_vd),
      .ld_word(mem_rsp_rdata[g*DW +: DW]), .st_va(lat_va),
      .st_word(mem_req_wdata[g*DW +: DW]), .flag_q(flag_vec[g]), .wr_ev(wr_mask[g])
    );
  end

endmodule

// File: rtl/vsimd_chk.sv
module vsimd_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  parameter int BW    = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic [BW-1:0]    mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic             waiting,
  input logic             cmp_fire,
  input logic             pred_alu_fire,
  input logic [LANES-1:0] flag_vec,
  input logic [LANES-1:0] wr_mask
);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  assert_no_issue_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || waiting) |-> !in_ready);

  assert_ready_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && mem_rsp_valid) |=> in_ready);

  assert_flag_only_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> $stable(flag_vec));

  assert_pred_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_alu_fire |-> ((wr_mask & ~flag_vec) == '0));

endmodule

bind vsimd_unit vsimd_chk #(.LANES(LANES), .AW(AW), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid), .waiting(waiting), .cmp_fire(cmp_fire),
  .pred_alu_fire(pred_alu_fire), .flag_vec(flag_vec), .wr_mask(wr_mask)
);

// File: tb/vsimd_unit_tb.sv
module vsimd_unit_tb_top;

  localparam int L = 16;
  localparam int W = 32;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_op = '0;
  logic in_pred = 1'b0;
  logic [2:0] in_vd = '0, in_va = '0, in_vb = '0;
  logic [W-1:0] in_imm = '0, in_base = '0;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [W-1:0] mem_req_addr;
  logic [L*W-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [L*W-1:0] mem_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  vsimd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_pred(in_pred), .in_vd(in_vd), .in_va(in_va), .in_vb(in_vb), .in_imm(in_imm),
    .in_base(in_base), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit m_busy = 1'b0;
  bit m_req = 1'b0;
  bit live = 1'b0;
  logic [W-1:0] m_rf [L][N];
  bit m_fl [L];

  task automatic check(input bit ok, input string req, input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison of the handshake outputs against the model's phase
  always @(negedge clk) if (live) begin
    check(in_ready == !m_busy, "R8 in_ready", in_ready, !m_busy);
    check(mem_req_valid == m_req, "R8 mem_req_valid", mem_req_valid, m_req);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic alu(input int op, input bit p, input int vd, input int va, input int vb, input logic [W-1:0] imm);
    logic [W-1:0] a, b;
    @(negedge clk);
    in_valid = 1; in_op = 3'(op); in_pred = p; in_vd = 3'(vd); in_va = 3'(va); in_vb = 3'(vb); in_imm = imm;
    @(posedge clk); #1 in_valid = 0;
    for (int i = 0; i < L; i++) begin
      a = m_rf[i][va]; b = m_rf[i][vb];
      if (op == 3) m_fl[i] = ($signed(a) < $signed(b));
      else if (!p || m_fl[i]) begin
        if (op == 1) m_rf[i][vd] = a + b;
        if (op == 2) m_rf[i][vd] = a + imm;
      end
    end
  endtask

  task automatic mem(input bit wr, input bit p, input int r, input logic [W-1:0] base,
                     input int rq_wait, input int rs_wait, input logic [L*W-1:0] data, input string tag);
    logic [L*W-1:0] exp;
    for (int i = 0; i < L; i++) exp[i*W +: W] = m_rf[i][r];
    @(negedge clk);
    in_valid = 1; in_op = wr ? 3'd5 : 3'd4; in_pred = p; in_vd = 3'(r); in_va = 3'(r); in_base = base;
    @(posedge clk); #1 in_valid = 0; m_busy = 1; m_req = 1;
    for (int k = 0; k <= rq_wait; k++) begin
      @(negedge clk);
      check(mem_req_addr == base && mem_req_write == wr, {tag, " addr/dir"},
            {mem_req_write, mem_req_addr}, {wr, base});
      if (wr) check(mem_req_wdata == exp, tag, mem_req_wdata, exp);
      if (k == rq_wait) mem_req_ready = 1;
    end
    @(posedge clk); #1 mem_req_ready = 0; m_req = 0;
    for (int k = 0; k < rs_wait; k++) @(posedge clk);
    @(negedge clk); mem_rsp_valid = 1; mem_rsp_rdata = data;
    @(posedge clk); #1 mem_rsp_valid = 0; mem_rsp_rdata = '0; m_busy = 0;
    if (!wr) for (int i = 0; i < L; i++) if (!p || m_fl[i]) m_rf[i][r] = data[i*W +: W];
  endtask

  task automatic rd(input int r, input string tag);
    mem(1'b1, 1'b0, r, 32'h1000 + 32'(r) * 64, 1, 0, '0, tag);
  endtask

  function automatic logic [L*W-1:0] blk(input int sel);
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++)
      case (sel)
        0: v[i*W +: W] = W'((i - 8) * 1000);
        1: v[i*W +: W] = (i % 3 == 0) ? W'((i - 8) * 1000) : W'(i * 77 - 500);
        2: v[i*W +: W] = 32'hFFFF_FFF0 + W'(i);
        default: v[i*W +: W] = 32'hA5A5_0000 | W'(i);
      endcase
    return v;
  endfunction

  initial begin
    for (int i = 0; i < L; i++) begin
      m_fl[i] = 1;
      for (int r = 0; r < N; r++) m_rf[i][r] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;
    @(negedge clk);
    check(in_ready == 1 && mem_req_valid == 0, "R1 reset handshake", {in_ready, mem_req_valid}, 2'b10);
    rd(3, "R1 reset regs zero");
    alu(2, 1, 4, 4, 0, 32'd9);
    rd(4, "R1 flags true: predicated addc");
    mem(1'b0, 1'b0, 1, 32'h0000_2000, 0, 0, blk(0), "R6 load");
    mem(1'b0, 1'b0, 2, 32'h0000_2040, 3, 2, blk(1), "R6 load");
    rd(1, "R6 v1 lanes");
    mem(1'b1, 1'b0, 2, 32'h0000_3000, 4, 3, '0, "R7 store stalled");
    mem(1'b0, 1'b0, 5, 32'h0000_2080, 1, 1, blk(2), "R6 load");
    alu(1, 0, 3, 5, 5, '0);
    rd(3, "R2 add wraps");
    alu(2, 0, 6, 1, 0, 32'h7FFF_FFFF);
    rd(6, "R3 addc");
    alu(3, 1, 0, 1, 2, '0);
    rd(1, "R4 compare keeps regs");
    alu(2, 1, 7, 7, 0, 32'd5);
    rd(7, "R5 predicated addc");
    alu(1, 1, 6, 6, 1, '0);
    rd(6, "R5 predicated add");
    alu(1, 0, 4, 4, 2, '0);
    rd(4, "R9 unpredicated add");
    mem(1'b1, 1'b1, 4, 32'h0000_3100, 0, 0, '0, "R7 store ignores predicate");
    mem(1'b0, 1'b1, 5, 32'h0000_20C0, 2, 0, blk(3), "R10 predicated load");
    rd(5, "R10 masked lanes");
    alu(3, 0, 0, 2, 2, '0);
    alu(2, 1, 3, 3, 0, 32'd1);
    rd(3, "R4 equal gives false");
    alu(3, 0, 0, 5, 1, '0);
    alu(2, 1, 1, 1, 0, 32'd100);
    rd(1, "R5 second flag pattern");
    repeat (3) @(posedge clk);
    live = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule